// File: doc/BRIEF.md
# Offset-Start Source Clock Divider

The block derives a slower clock from a source clock. A counter climbs from a lower bound to an upper bound and then returns to the lower bound. The divided output is high for the half of that span where the counter's top bit is set, and low for the rest. The lower bound, the upper bound, the counter width and a start offset are all parameters. At reset the counter is placed below the upper bound by the offset, which fixes the phase of the divided clock relative to reset release.

A gate input decides whether edges are produced at all. The gate is sampled only while the divided clock is in its low half, and again at the wrap. A rising edge happens only if the gate sampled on that cycle is open. A falling edge happens only if the gate that was held through the high half is open. Besides the level itself, the block provides the held gate value, a ready flag one cycle before the rising transition point, and one-cycle strobes that mark each rising and each falling edge. Reset is synchronous and active low. While reset is held the counter stays at its reload value.

Top module: `ofs_clk_div`

## Requirements
- R1: While `rst_n_i` is sampled low, the counter is held at UPPER-OFFSET and `gate_en_o` is 0. After every such edge, `clk_div_o` is 1 if UPPER-OFFSET >= 2^(CNT_W-1), and 0 otherwise.
- R2: On the edge where reset moves the counter from below the threshold 2^(CNT_W-1) to at or above it, `rise_o` pulses for one cycle. The mirror case pulses `fall_o`. Later reset edges pulse neither.
- R3: Outside reset, the counter advances by one on each source edge and goes from UPPER to LOWER, so `ready_o` repeats every UPPER-LOWER+1 cycles.
- R4: `ready_o` is 1 exactly while the counter equals 2^(CNT_W-1)-1.
- R5: `gate_en_o` loads `gate_i` on every edge taken while the counter is below the threshold, and also on the wrap edge. On all other edges it holds its value.
- R6: On the edge where the counter steps from threshold-1 to the threshold with `gate_i` = 1, `clk_div_o` becomes 1 and `rise_o` is 1 for that one cycle.
- R7: On the wrap edge with `gate_en_o` = 1, `clk_div_o` becomes 0 and `fall_o` is 1 for that one cycle.
- R8: Outside reset, `clk_div_o` changes only together with a strobe. A gate held at 0 through the low half produces no strobe and leaves the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src_i | input | 1 | Source clock |
| rst_n_i | input | 1 | Synchronous reset, active low |
| gate_i | input | 1 | Gate request, 1 lets edges through |
| clk_div_o | output | 1 | Divided clock level |
| gate_en_o | output | 1 | Gate value held for the current half |
| ready_o | output | 1 | Counter is one step before the rising point |
| rise_o | output | 1 | One-cycle strobe on a rising edge |
| fall_o | output | 1 | One-cycle strobe on a falling edge |

## Verification
The assertions assume three things. Reset is low from time zero and stays low for at least one source edge. `gate_i` settles between edges. The parameters meet LOWER < threshold <= UPPER < 2^CNT_W, with the offset no larger than UPPER-LOWER. The stimulus keeps to this. It changes reset and gate only at the falling source edge, starts in reset, and uses the default parameters, which meet the bounds. Gate patterns cover an always-open gate, a gate that toggles partway through both halves, and a gate that stays closed. A reset is also issued in the middle of a low half, so that the reload crosses the threshold.

// File: rtl/ocd_pkg.sv
`timescale 1ns/1ps
package ocd_pkg;
  // Transition point: only the counter's top bit set
  function automatic int unsigned thr_of(input int unsigned w);
    return 32'd1 << (w - 1);
  endfunction

  // Value loaded while reset is asserted
  function automatic int unsigned reload_of(input int unsigned hi, input int unsigned ofs);
    return hi - ofs;
  endfunction

  // Output level that a given counter value implies
  function automatic bit high_half(input int unsigned cnt, input int unsigned w);
    return cnt >= thr_of(w);
  endfunction

  // Legal parameter set
  function automatic bit bounds_ok(input int unsigned w, input int unsigned lo,
                                   input int unsigned hi, input int unsigned ofs);
    return (lo < thr_of(w)) && (thr_of(w) <= hi) && (hi < (32'd1 << w)) && (ofs <= hi - lo);
  endfunction
endpackage

// File: rtl/ocd_counter.sv
`timescale 1ns/1ps
module ocd_counter #(
  parameter int unsigned W   = 4,
  parameter int unsigned LO  = 2,
  parameter int unsigned HI  = 13,
  parameter int unsigned OFS = 3
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  output logic [W-1:0] cnt_o,
  output logic         at_upper_o,
  output logic         below_o,
  output logic         pre_thr_o
);
  localparam logic [W-1:0] THR_V = W'(ocd_pkg::thr_of(W));
  localparam logic [W-1:0] LO_V  = W'(LO);
  localparam logic [W-1:0] HI_V  = W'(HI);
  localparam logic [W-1:0] RLD_V = W'(ocd_pkg::reload_of(HI, OFS));
  localparam logic [W-1:0] ONE_V = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_n_i)        cnt_q <= RLD_V;
    else if (at_upper_o) cnt_q <= LO_V;
    else                 cnt_q <= cnt_q + ONE_V;
  end

  assign cnt_o      = cnt_q;
  assign at_upper_o = (cnt_q == HI_V);
  assign below_o    = (cnt_q < THR_V);
  assign pre_thr_o  = (cnt_q == THR_V - ONE_V);

  // R3: wrap from the upper bound lands on the lower bound
  a_r3_wrap_to_lower: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    at_upper_o |=> (cnt_q == LO_V));
  // R3: plain step otherwise
  a_r3_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !at_upper_o |=> (cnt_q == $past(cnt_q) + ONE_V));
  // R4: ready is followed by the transition point
  a_r4_ready_then_thr: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    pre_thr_o |=> (cnt_q == THR_V));
endmodule

// File: rtl/ocd_gate.sv
`timescale 1ns/1ps
module ocd_gate (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic gate_i,
  input  logic below_i,
  input  logic at_upper_i,
  output logic gate_q_o
);
  logic gate_q;
  logic capture;

  // Open window: low half, plus the wrap edge
  assign capture = below_i || at_upper_i;

  always_ff @(posedge clk_i) begin
    if (!rst_n_i)     gate_q <= 1'b0;
    else if (capture) gate_q <= gate_i;
  end

  assign gate_q_o = gate_q;

  // R5: the held gate does not move in the high half away from the wrap
  a_r5_gate_holds_high_half: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!below_i && !at_upper_i) |=> $stable(gate_q));
  // R5: inside the window the held gate follows the input
  a_r5_gate_follows_window: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    capture |=> (gate_q == $past(gate_i)));
endmodule

// File: rtl/ocd_edge.sv
`timescale 1ns/1ps
module ocd_edge #(
  parameter int unsigned W   = 4,
  parameter int unsigned HI  = 13,
  parameter int unsigned OFS = 3
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic gate_i,
  input  logic gate_q_i,
  input  logic below_i,
  input  logic pre_thr_i,
  input  logic at_upper_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  localparam bit RLD_HIGH = ocd_pkg::high_half(ocd_pkg::reload_of(HI, OFS), W);

  logic lvl_q, rise_q, fall_q;
  logic run_rise, run_fall, rst_rise, rst_fall;

  // Rising point uses the gate sampled on this same edge
  assign run_rise = pre_thr_i && gate_i;
  assign run_fall = at_upper_i && gate_q_i;
  // Reload moving the counter across the threshold
  assign rst_rise = below_i && RLD_HIGH;
  assign rst_fall = !below_i && !RLD_HIGH;

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      lvl_q  <= RLD_HIGH;
      rise_q <= rst_rise;
      fall_q <= rst_fall;
    end else begin
      rise_q <= run_rise;
      fall_q <= run_fall;
      if (run_rise)      lvl_q <= 1'b1;
      else if (run_fall) lvl_q <= 1'b0;
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;

  // R6: a rise strobe comes with a high level
  a_r6_rise_level_high: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    rise_o |-> lvl_o);
  // R6: outside reset a rise needs the step to the threshold with gate open
  a_r6_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (rise_o && $past(rst_n_i)) |-> $past(pre_thr_i && gate_i));
  // R7: a fall strobe comes with a low level
  a_r7_fall_level_low: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    fall_o |-> !lvl_o);
  // R2: never both strobes at once
  a_r2_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !(rise_o && fall_o));
  // R8: level moves only with a strobe
  a_r8_level_only_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ($past(rst_n_i) && !rise_o && !fall_o) |-> $stable(lvl_o));
endmodule

// File: rtl/ofs_clk_div.sv
`timescale 1ns/1ps
module ofs_clk_div #(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned LOWER  = 2,
  parameter int unsigned UPPER  = 13,
  parameter int unsigned OFFSET = 3
) (
  input  logic clk_src_i,
  input  logic rst_n_i,
  input  logic gate_i,
  output logic clk_div_o,
  output logic gate_en_o,
  output logic ready_o,
  output logic rise_o,
  output logic fall_o
);
  if (!ocd_pkg::bounds_ok(CNT_W, LOWER, UPPER, OFFSET)) begin : g_bad_bounds
    $error("ofs_clk_div: bounds violate LOWER < threshold <= UPPER < 2^CNT_W or OFFSET too large");
  end

  logic [CNT_W-1:0] cnt;
  logic at_upper, below, pre_thr, gate_q;

  ocd_counter #(.W(CNT_W), .LO(LOWER), .HI(UPPER), .OFS(OFFSET)) u_cnt (
    .clk_i(clk_src_i), .rst_n_i(rst_n_i), .cnt_o(cnt),
    .at_upper_o(at_upper), .below_o(below), .pre_thr_o(pre_thr)
  );

  ocd_gate u_gate (
    .clk_i(clk_src_i), .rst_n_i(rst_n_i), .gate_i(gate_i),
    .below_i(below), .at_upper_i(at_upper), .gate_q_o(gate_q)
  );

  ocd_edge #(.W(CNT_W), .HI(UPPER), .OFS(OFFSET)) u_edge (
    .clk_i(clk_src_i), .rst_n_i(rst_n_i), .gate_i(gate_i), .gate_q_i(gate_q),
    .below_i(below), .pre_thr_i(pre_thr), .at_upper_i(at_upper),
    .lvl_o(clk_div_o), .rise_o(rise_o), .fall_o(fall_o)
  );

  assign gate_en_o = gate_q;
  assign ready_o   = pre_thr;

  // R1: reload value is seen after a reset edge
  a_r1_reload: assert property (@(posedge clk_src_i)
    $past(!rst_n_i) |-> (gate_en_o == 1'b0 && !ready_o &&
                         cnt == CNT_W'(ocd_pkg::reload_of(UPPER, OFFSET))));
endmodule

// File: tb/ofs_clk_div_tb_top.sv
`timescale 1ns/1ps
module ofs_clk_div_tb_top;
  localparam int W = 4, LO = 2, HI = 13, OFS = 3;
  localparam int T = 1 << (W - 1);
  localparam int RLD = HI - OFS;

  typedef struct {
    bit    chk;
    bit    rst;
    string tag;
    bit    lvl, gate, rdy, rise, fall;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate_in = 1'b0;
  logic clk_div, gate_en, ready, rise, fall;

  int n_cmp = 0;
  int n_bad = 0;
  exp_t q[$];

  // reference state
  int m_cnt = RLD;
  bit m_gate = 1'b0;
  bit m_lvl = (RLD >= T);

  always #10 clk = ~clk;

  ofs_clk_div #(.CNT_W(W), .LOWER(LO), .UPPER(HI), .OFFSET(OFS)) dut_i (
    .clk_src_i(clk), .rst_n_i(rst_n), .gate_i(gate_in),
    .clk_div_o(clk_div), .gate_en_o(gate_en), .ready_o(ready),
    .rise_o(rise), .fall_o(fall)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // driver: apply inputs at the falling edge and predict the state after the next rising edge
  task automatic step(input bit r, input bit g, input bit c, input string tag);
    exp_t e;
    bit rs, fl, ng;
    @(negedge clk);
    rst_n   = r;
    gate_in = g;
    rs = 1'b0; fl = 1'b0;
    if (!r) begin
      rs = (m_cnt < T) && (RLD >= T);
      fl = (m_cnt >= T) && (RLD < T);
      m_cnt = RLD; m_gate = 1'b0; m_lvl = (RLD >= T);
    end else begin
      ng = m_gate;
      if (m_cnt < T) ng = g;
      if (m_cnt == HI) begin
        if (m_gate) begin fl = 1'b1; m_lvl = 1'b0; end
        ng = g;
        m_cnt = LO;
      end else begin
        m_cnt = m_cnt + 1;
        if (m_cnt == T && ng) begin rs = 1'b1; m_lvl = 1'b1; end
      end
      m_gate = ng;
    end
    e.chk = c; e.rst = !r; e.tag = tag;
    e.lvl = m_lvl; e.gate = m_gate; e.rdy = (m_cnt == T - 1);
    e.rise = rs; e.fall = fl;
    q.push_back(e);
  endtask

  // monitor: sample 5 ns after each rising edge
  int since = 0;
  bit since_ok = 1'b0;
  always @(posedge clk) begin
    exp_t e;
    #5;
    if (q.size() > 0) begin
      e = q.pop_front();
      if (e.chk) begin
        cmp(e.tag != "" ? e.tag : (e.rst ? "R1" : "R6"), "clk_div_o", clk_div, e.lvl);
        cmp(e.tag != "" ? e.tag : (e.rst ? "R1" : "R5"), "gate_en_o", gate_en, e.gate);
        cmp(e.tag != "" ? e.tag : (e.rst ? "R1" : "R4"), "ready_o", ready, e.rdy);
        cmp(e.tag != "" ? e.tag : (e.rst ? "R2" : "R6"), "rise_o", rise, e.rise);
        cmp(e.tag != "" ? e.tag : (e.rst ? "R2" : "R7"), "fall_o", fall, e.fall);
      end
      if (e.rst) begin
        since_ok = 1'b0;
        since = 0;
      end else begin
        since++;
        if (ready) begin
          if (since_ok) cmp("R3", "ready period", since, HI - LO + 1);
          since_ok = 1'b1;
          since = 0;
        end
      end
    end
  end

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // first reset edge: prior state unknown, no check
    step(1'b0, 1'b0, 1'b0, "");
    // R1: held reset
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, "R1");
    // R4 R5 R6 R7: gate always open
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1'b1, "");
    // R5: gate toggling in both halves
    for (int i = 0; i < 50; i++) step(1'b1, (i % 5) != 0, 1'b1, "");
    for (int i = 0; i < 30; i++) step(1'b1, (i % 3) == 1, 1'b1, "R5");
    // R8: gate closed
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b1, "R8");
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b1, "");
    // R2: reset taken in the low half crosses the threshold upward
    while (m_cnt >= T) step(1'b1, 1'b1, 1'b1, "");
    step(1'b0, 1'b1, 1'b1, "R2");
    step(1'b0, 1'b1, 1'b1, "R2");
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1'b1, "");
    // reset taken in the high half: no strobe
    while (m_cnt < T) step(1'b1, 1'b1, 1'b1, "");
    step(1'b0, 1'b0, 1'b1, "R2");
    for (int i = 0; i < 30; i++) step(1'b1, 1'b1, 1'b1, "");
    repeat (3) @(negedge clk);
    cmp("R3", "queue drained", q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule